// File: doc/BRIEF.md
# Byte-Select SRAM Cycle Generator

This block runs bus cycles for one chip-select area that holds a static RAM with per-byte select lines. A host-side agent offers a request through a valid/ready handshake. Each request carries an address, a byte-lane mask, a read/write flag and write data. The block then sequences chip select, read strobe, the write line, the active-low per-lane enables and the write-data drivers. A one-cycle acknowledge marks the end of every access, and for reads it comes with the captured data.

A small configuration word holds three fields. A 4-bit wait code picks how many extra cycles a read waits before its strobe cycle. A mode bit decides which line acts as the strobe: the byte-lane enables or the write line. The third field is a sticky flag that records an attempt to write a prohibited wait code. Each access latches the wait count and the mode when it is accepted, so writing the configuration mid-access has no effect on that access.

The cycle engine has five states. ST_IDLE goes to ST_ADDR when a request is accepted. ST_ADDR goes to ST_WAIT for a read with a non-zero wait count, and otherwise goes to ST_STRB. ST_WAIT stays until its counter expires, then goes to ST_STRB. ST_STRB always goes to ST_END, and ST_END always goes back to ST_IDLE.

Top module: `bsram_cyc`

## Requirements
- R1: After reset the configuration word reads 0x0000000A: wait code 1010 in bits [3:0], mode bit [4] at 0 and error flag [8] at 0. The bus is idle with mem_cs_n, mem_rd_n, mem_wr_n and every mem_be_n bit high, mem_doe low, req_ready high, rsp_ack low and rsp_rdata zero.
- R2: A read inserts N wait cycles between the address cycle and the strobe cycle. Codes 0 to 6 give N equal to the code. Codes 7, 8, 9, 10, 11 and 12 give 8, 10, 12, 14, 18 and 24. A write has no wait cycles.
- R3: Writing code 13, 14 or 15 leaves the previous wait code in bits [3:0] unchanged and sets the error flag in bit [8]. The flag stays set until reset. The mode bit in the same write is still taken.
- R4: Configuration bits other than [4:0] and [8] always read 0, and write data in those positions has no effect. Bit [8] cannot be written.
- R5: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is high only in the idle state. The access then lasts one address cycle, the wait cycles, one strobe cycle and one end cycle, and mem_cs_n is low through all of them.
- R6: With mode 0, mem_be_n bit i goes low only in the strobe cycle and only if req_be bit i was set. On a write, mem_wr_n is low from the address cycle through the strobe cycle.
- R7: With mode 1, mem_be_n bit i is low from the address cycle through the strobe cycle if req_be bit i was set. On a write, mem_wr_n is low only in the strobe cycle.
- R8: mem_rd_n is low during the wait and strobe cycles of a read and high at all other times.
- R9: Read data on mem_din is captured on the clock edge that ends the strobe cycle. rsp_ack is high for exactly the end cycle of every access. rsp_rdata holds the last captured read data until the next read captures new data.
- R10: For a write, mem_doe is high and mem_dout equals the request's write data from the address cycle through the end cycle. mem_doe is low in idle and throughout reads.
- R11: The wait count and mode in force at acceptance govern the whole access. A configuration write during an access does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | CFG_W | Configuration write data |
| cfg_rdata | output | CFG_W | Configuration read value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_be | input | DW/8 | Byte-lane mask, bit i = lane i |
| req_wdata | input | DW | Write data |
| rsp_ack | output | 1 | Access complete (one cycle) |
| rsp_rdata | output | DW | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write line, active low |
| mem_be_n | output | DW/8 | Per-lane enables, active low |
| mem_addr | output | AW | Memory address |
| mem_dout | output | DW | Write data to memory |
| mem_doe | output | 1 | Write-data output enable |
| mem_din | input | DW | Read data from memory |

## Verification
The assertions assume that req_valid, the request fields and the configuration inputs change only between clock edges. They also assume that the memory's read data is steady on the edge that ends the strobe cycle. The bench drives every input on the falling edge and changes mem_din only while no access is in flight. It never offers a request on the same edge as a configuration write, so the value latched at acceptance is unambiguous. Configuration writes during an access are issued only after the request has been accepted.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int WCODE_W   = 4;
    localparam int CNT_W     = 5;
    localparam int WCODE_MAX = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_STRB,
        ST_END
    } cyc_state_t;

    function automatic logic [CNT_W-1:0] wait_decode(input logic [WCODE_W-1:0] code);
        logic [CNT_W-1:0] n;
        unique case (code)
            4'd7:    n = CNT_W'(8);
            4'd8:    n = CNT_W'(10);
            4'd9:    n = CNT_W'(12);
            4'd10:   n = CNT_W'(14);
            4'd11:   n = CNT_W'(18);
            4'd12:   n = CNT_W'(24);
            4'd13, 4'd14, 4'd15: n = CNT_W'(0);
            default: n = CNT_W'(code);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bsram_cfg_reg.sv
module bsram_cfg_reg
    import bsram_pkg::*;
#(
    parameter int CFG_W = 32,
    parameter logic [WCODE_W-1:0] RST_CODE = 4'b1010
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output logic [WCODE_W-1:0]   wcode,
    output logic                 smode
);
    localparam int MODE_BIT = WCODE_W;
    localparam int ERR_BIT  = 8;

    logic [WCODE_W-1:0] code_q;
    logic               mode_q;
    logic               err_q;
    logic               code_ok;
    logic               unused_wbits;

    assign code_ok      = (cfg_wdata[WCODE_W-1:0] <= WCODE_W'(WCODE_MAX));
    assign unused_wbits = ^{cfg_wdata[CFG_W-1:MODE_BIT+1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= RST_CODE;
            mode_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (cfg_we) begin
            mode_q <= cfg_wdata[MODE_BIT];
            if (code_ok) begin
                code_q <= cfg_wdata[WCODE_W-1:0];
            end else begin
                err_q  <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg_rdata                  = '0;
        cfg_rdata[WCODE_W-1:0]     = code_q;
        cfg_rdata[MODE_BIT]        = mode_q;
        cfg_rdata[ERR_BIT]         = err_q;
    end

    assign wcode = code_q;
    assign smode = mode_q;

endmodule

// File: rtl/bsram_wait_dec.sv
module bsram_wait_dec
    import bsram_pkg::*;
(
    input  logic [WCODE_W-1:0] wcode,
    output logic [CNT_W-1:0]   wcount
);
    assign wcount = wait_decode(wcode);
endmodule

// File: rtl/bsram_fsm.sv
module bsram_fsm
    import bsram_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  wcount,
    input  logic              smode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [AW-1:0]     req_addr,
    input  logic [NB-1:0]     req_be,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_ack,
    output logic [DW-1:0]     rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [NB-1:0]     mem_be_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_dout,
    output logic              mem_doe,
    input  logic [DW-1:0]     mem_din
);
    cyc_state_t        state, nxt;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  lat_n;
    logic              lat_wr;
    logic              lat_mode;
    logic [NB-1:0]     lat_be;
    logic [AW-1:0]     lat_addr;
    logic [DW-1:0]     lat_wdata;
    logic [DW-1:0]     rd_q;
    logic              accept;

    assign accept = (state == ST_IDLE) && req_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_ADDR;
            ST_ADDR: nxt = (!lat_wr && (lat_n != '0)) ? ST_WAIT : ST_STRB;
            ST_WAIT: if (cnt_q == CNT_W'(1)) nxt = ST_STRB;
            ST_STRB: nxt = ST_END;
            ST_END:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_n     <= '0;
            lat_wr    <= 1'b0;
            lat_mode  <= 1'b0;
            lat_be    <= '0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            cnt_q     <= '0;
        end else if (accept) begin
            lat_n     <= req_wr ? '0 : wcount;
            lat_wr    <= req_wr;
            lat_mode  <= smode;
            lat_be    <= req_be;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            cnt_q     <= req_wr ? '0 : wcount;
        end else if (state == ST_WAIT) begin
            cnt_q     <= cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rd_q <= '0;
        else if (state == ST_STRB && !lat_wr) rd_q <= mem_din;
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_ack   = 1'b0;
        mem_cs_n  = 1'b1;
        mem_rd_n  = 1'b1;
        mem_wr_n  = 1'b1;
        mem_be_n  = '1;
        mem_doe   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ADDR: begin
                mem_cs_n = 1'b0;
                mem_doe  = lat_wr;
                mem_wr_n = !(lat_wr && !lat_mode);
                mem_be_n = lat_mode ? ~lat_be : '1;
            end
            ST_WAIT: begin
                mem_cs_n = 1'b0;
                mem_rd_n = 1'b0;
                mem_be_n = lat_mode ? ~lat_be : '1;
            end
            ST_STRB: begin
                mem_cs_n = 1'b0;
                mem_rd_n = lat_wr;
                mem_wr_n = !lat_wr;
                mem_doe  = lat_wr;
                mem_be_n = ~lat_be;
            end
            ST_END: begin
                mem_cs_n = 1'b0;
                mem_doe  = lat_wr;
                rsp_ack  = 1'b1;
            end
            default: begin
                req_ready = 1'b0;
            end
        endcase
    end

    assign mem_addr  = lat_addr;
    assign mem_dout  = lat_wdata;
    assign rsp_rdata = rd_q;

endmodule

// File: rtl/bsram_cyc.sv
module bsram_cyc
    import bsram_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CFG_W = 32,
    localparam int NB   = DW / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_wr,
    input  logic [AW-1:0]     req_addr,
    input  logic [NB-1:0]     req_be,
    input  logic [DW-1:0]     req_wdata,
    output logic              rsp_ack,
    output logic [DW-1:0]     rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_wr_n,
    output logic [NB-1:0]     mem_be_n,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_dout,
    output logic              mem_doe,
    input  logic [DW-1:0]     mem_din
);
    logic [WCODE_W-1:0] wcode;
    logic               smode;
    logic [CNT_W-1:0]   wcount;

    bsram_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .wcode     (wcode),
        .smode     (smode)
    );

    bsram_wait_dec u_dec (
        .wcode  (wcode),
        .wcount (wcount)
    );

    bsram_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wcount    (wcount),
        .smode     (smode),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_wr    (req_wr),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .mem_cs_n  (mem_cs_n),
        .mem_rd_n  (mem_rd_n),
        .mem_wr_n  (mem_wr_n),
        .mem_be_n  (mem_be_n),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .mem_doe   (mem_doe),
        .mem_din   (mem_din)
    );

endmodule

// File: rtl/bsram_cyc_chk.sv
module bsram_cyc_chk #(
    parameter int NB    = 4,
    parameter int CFG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_ack,
    input logic             mem_cs_n,
    input logic             mem_rd_n,
    input logic             mem_wr_n,
    input logic [NB-1:0]    mem_be_n,
    input logic             mem_doe,
    input logic [CFG_W-1:0] cfg_rdata
);
    AST_READY_ONLY_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> mem_cs_n);                    // R5
    AST_ACCEPT_STARTS:     assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !mem_cs_n);   // R5
    AST_ACK_SINGLE:        assert property (@(posedge clk) disable iff (!rst_n) rsp_ack |=> !rsp_ack);                     // R9
    AST_ACK_THEN_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) rsp_ack |=> (mem_cs_n && req_ready));      // R5
    AST_RD_WR_EXCL:        assert property (@(posedge clk) disable iff (!rst_n) !(!mem_rd_n && !mem_wr_n));                // R8
    AST_BE_INSIDE_CS:      assert property (@(posedge clk) disable iff (!rst_n) !(&mem_be_n) |-> !mem_cs_n);               // R6
    AST_DOE_INSIDE_CS:     assert property (@(posedge clk) disable iff (!rst_n) mem_doe |-> !mem_cs_n);                    // R10
    AST_WR_NEEDS_DOE:      assert property (@(posedge clk) disable iff (!rst_n) !mem_wr_n |-> mem_doe);                    // R10
    AST_READ_NO_DOE:       assert property (@(posedge clk) disable iff (!rst_n) !mem_rd_n |-> !mem_doe);                   // R10
    AST_ERR_STICKY:        assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[8] |=> cfg_rdata[8]);            // R3
    AST_CODE_LEGAL:        assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[3:0] <= 4'd12);                  // R3
    AST_UNUSED_ZERO:       assert property (@(posedge clk) disable iff (!rst_n)
                               (cfg_rdata[CFG_W-1:9] == '0) && (cfg_rdata[7:5] == 3'b000));                               // R4
endmodule

bind bsram_cyc bsram_cyc_chk #(.NB(NB), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/bsram_cyc_bench.sv
module bsram_cyc_bench;
    localparam int CLK_PER = 10;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int NB = DW / 8;
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [NB-1:0] req_be = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_ack;
    logic [DW-1:0] rsp_rdata;
    logic mem_cs_n, mem_rd_n, mem_wr_n, mem_doe;
    logic [NB-1:0] mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic [DW-1:0] mem_din = '0;

    always #(CLK_PER/2) clk = ~clk;

    bsram_cyc u_bsram_cyc (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // behavioural reference state
    int m_code, m_mode, m_err;
    bit busy;
    int k, n, m_wr, m_amode;
    logic [NB-1:0] m_be;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, m_rd;

    function automatic int wait_of(int c);
        int tbl[6] = '{8, 10, 12, 14, 18, 24};
        if (c <= 6) return c;
        return tbl[c - 7];
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #(CLK_PER/4);
        if (!rst_n) begin
            m_code = 10; m_mode = 0; m_err = 0; busy = 0; m_rd = '0; k = 0; n = 0;
        end else begin
            if (busy) begin
                if (k == n + 1 && m_wr == 0) m_rd = mem_din;
                if (k == n + 2) busy = 0; else k++;
            end else if (req_valid) begin
                busy = 1; k = 0; m_wr = req_wr;
                n = req_wr ? 0 : wait_of(m_code);
                m_amode = m_mode; m_be = req_be; m_addr = req_addr; m_wdata = req_wdata;
            end
            if (cfg_we) begin
                if (cfg_wdata[3:0] > 12) m_err = 1; else m_code = int'(cfg_wdata[3:0]);
                m_mode = int'(cfg_wdata[4]);
            end
        end
        begin
            bit act_be, rd_on, wr_on;
            logic [NB-1:0] exp_be;
            logic [31:0] exp_cfg;
            exp_cfg = 32'(m_code) | (32'(m_mode) << 4) | (32'(m_err) << 8);
            act_be = busy && ((m_amode == 0) ? (k == n + 1) : (k <= n + 1));
            exp_be = act_be ? ~m_be : '1;
            rd_on  = busy && m_wr == 0 && k >= 1 && k <= n + 1;
            wr_on  = busy && m_wr == 1 && ((m_amode == 0) ? (k <= n + 1) : (k == n + 1));
            if (!rst_n) begin
                chk("R1 cfg_rdata", cfg_rdata, 32'h0000000A);
                chk("R1 idle bus", {mem_cs_n, mem_rd_n, mem_wr_n, mem_doe, req_ready, rsp_ack},
                    {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0});
                chk("R1 be_n", 32'(mem_be_n), 32'(4'hF));
                chk("R1 rdata", rsp_rdata, '0);
            end else begin
                chk("R3 R4 cfg_rdata", cfg_rdata, exp_cfg);
                chk("R5 req_ready", 32'(req_ready), 32'(!busy));
                chk("R5 mem_cs_n", 32'(mem_cs_n), 32'(!busy));
                chk("R2 R8 mem_rd_n", 32'(mem_rd_n), 32'(!rd_on));
                chk(m_amode == 0 ? "R6 R11 mem_wr_n" : "R7 R11 mem_wr_n", 32'(mem_wr_n), 32'(!wr_on));
                chk(m_amode == 0 ? "R6 mem_be_n" : "R7 mem_be_n", 32'(mem_be_n), 32'(exp_be));
                chk("R9 rsp_ack", 32'(rsp_ack), 32'(busy && k == n + 2));
                chk("R9 rsp_rdata", rsp_rdata, m_rd);
                chk("R10 mem_doe", 32'(mem_doe), 32'(busy && m_wr == 1));
                if (busy) chk("R5 mem_addr", 32'(mem_addr), 32'(m_addr));
                if (busy && m_wr == 1) chk("R10 mem_dout", mem_dout, m_wdata);
            end
        end
    end

    task automatic cfg_write(logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic access(bit wr, logic [AW-1:0] a, logic [NB-1:0] be, logic [DW-1:0] wd,
                          logic [31:0] mid_cfg = '0, bit mid = 0);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_wr = wr; req_addr = a; req_be = be; req_wdata = wd;
        mem_din = {a, ~a} ^ 32'h5A5A_0000;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~wd; req_be = ~be;
        if (mid) begin
            cfg_we = 1'b1; cfg_wdata = mid_cfg;
            @(negedge clk);
            cfg_we = 1'b0; cfg_wdata = '0;
        end
        while (!req_ready) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 and R2: read with the reset code (14 waits), mode 0
        access(0, 16'h1234, 4'hF, '0);
        // R2: every legal code for reads, mode 0, and writes
        for (int c = 0; c <= 12; c++) begin
            cfg_write(32'(c));
            access(0, 16'(16'h0100 + c), 4'b0011, '0);
            access(1, 16'(16'h0200 + c), 4'b1001, 32'hC0DE_0000 | 32'(c));
        end
        // R7: mode 1, partial lanes
        cfg_write(32'h0000_0013);
        access(0, 16'hBEEF, 4'b0101, '0);
        access(1, 16'hCAFE, 4'b0010, 32'hDEAD_BEEF);
        cfg_write(32'h0000_0010);
        access(0, 16'h0F0F, 4'b1000, '0);
        access(1, 16'hF0F0, 4'b1110, 32'h1357_9BDF);
        // R4: unused bits ignored
        cfg_write(32'hFFFF_FEE5);
        access(0, 16'h4444, 4'hF, '0);
        // R3: prohibited codes keep code, set sticky flag, mode still taken
        cfg_write(32'h0000_000D);
        access(0, 16'h5555, 4'b0110, '0);
        cfg_write(32'h0000_001E);
        cfg_write(32'h0000_000F);
        cfg_write(32'h0000_0002);
        access(1, 16'h6666, 4'hF, 32'h0BAD_F00D);
        // R11: configuration change during an access
        cfg_write(32'h0000_000B);
        access(0, 16'h7777, 4'hF, '0, 32'h0000_0010, 1);
        access(0, 16'h7778, 4'hF, '0, 32'h0000_0006, 1);
        access(1, 16'h7779, 4'b0001, 32'hAAAA_5555, 32'h0000_0000, 1);
        // R5: back-to-back requests with valid held high
        @(negedge clk);
        req_valid = 1'b1; req_wr = 1'b0; req_addr = 16'h9000; req_be = 4'hF;
        mem_din = 32'h0123_4567;
        repeat (30) @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog act=%0d exp=done", WDOG);
            finish_run();
        end
    end

endmodule